// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block gathers external interrupt lines into seven groups of 32 bits and gives each group one combined request line toward a downstream vectored interrupt controller. Each line is synchronised, then detected according to its own sensing type and active polarity. Edge-sensed lines latch a pending bit that software clears by writing one. Level-sensed lines report the present state of the line, so the pending bit stays set for as long as the source holds the line active.

Software reaches four register banks through a simple word-addressed write/read port. The banks hold polarity, pending status, enable and sensing type, with one 32-bit word per group in each bank. Line numbers map onto groups in reverse order, and the byte order inside each group is reversed. Two on-chip events feed dedicated bits of group 0. Fixed masks keep reserved bit positions at zero in every bank.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset, every register word reads zero and every combined request output is low.
- R2: The polarity, enable and type words of group g (0..6) are read and written at byte addresses 0x80+4g, 0xC0+4g and 0xE0+4g, and the status word is read at 0xA0+4g. Reads return the stored value on the same cycle. Unaligned or unmapped addresses read zero.
- R3: Input line n (0..127) drives group 6-(n>>5), bit ((24-(n&24))|(n&7)).
- R4: For an edge-type bit (type 0) with polarity 1, a rising input sets its status bit on the third rising clock edge after the change, and the bit stays set after the input falls.
- R5: For an edge-type bit with polarity 0, only a falling input sets the status bit, and a rising input has no effect.
- R6: Writing 1 to an edge-type status bit clears it on the next clock edge. Writing 0 leaves it unchanged.
- R7: For a level-type bit (type 1), the status bit equals "input equals polarity", delayed by three clock edges. Writing 1 to it has no effect while the input stays active.
- R8: Output grp_irq[6-g] is high exactly when some bit of group g has both its status and its enable set.
- R9: Group 1 and group 2 are fully masked, bits 28..31 of group 3 are masked, and only bits 0 and 2 of group 0 are usable. Masked bits read zero in all four banks and never raise a request.
- R10: Bit 0 of group 0 is fed by timer_evt and bit 2 of group 0 is fed by cable_evt.
- R11: Changing a polarity bit while the input is steady never sets an edge-type status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_lines | input | 128 | External interrupt lines 0..127 |
| timer_evt | input | 1 | Timer end-of-count event, group 0 bit 0 |
| cable_evt | input | 1 | Cable-detect event, group 0 bit 2 |
| grp_irq | output | 7 | Combined request per group, index 6-g |

## Verification
An input change reaches its status bit and its group request on the third rising edge after it is driven: two edges in the synchroniser and one in the status register. The bench therefore checks at the falling edge after two rising edges that nothing has happened yet, and checks again one edge later for the result. A register write, including a status clear, takes effect at the single rising edge that follows it. Register reads are combinational and are sampled a short delay after the address settles, away from any rising edge.

// File: rtl/eic_pkg.sv
// Package: shared sizes, register bank codes and the line-to-group map.
// Assumes a fixed arrangement of seven 32-bit groups, with groups 6..3 fed by pins.
package eic_pkg;
    localparam int GROUPS    = 7;
    localparam int GW        = 32;
    localparam int LINES     = 128;
    localparam int ADDR_W    = 8;
    localparam int SYNC      = 2;
    localparam int GSEL_W    = $clog2(GROUPS);
    localparam int TMR_BIT   = 0;
    localparam int CBL_BIT   = 2;

    localparam logic [2:0] BANK_POL  = 3'd4;
    localparam logic [2:0] BANK_STAT = 3'd5;
    localparam logic [2:0] BANK_EN   = 3'd6;
    localparam logic [2:0] BANK_TYPE = 3'd7;

    typedef logic [GW-1:0] gvec_t;

    // usable bits of a group
    function automatic gvec_t grp_mask(input int g);
        case (g)
            0:       return gvec_t'((1 << TMR_BIT) | (1 << CBL_BIT));
            1, 2:    return '0;
            3:       return gvec_t'(32'h0FFF_FFFF);
            default: return '1;
        endcase
    endfunction

    // group fed by line n
    function automatic int line_group(input int n);
        return GROUPS - 1 - (n >> 5);
    endfunction

    // bit inside the group fed by line n (byte order reversed)
    function automatic int line_bit(input int n);
        return (24 - (n & 24)) | (n & 7);
    endfunction
endpackage

// File: rtl/eic_line_map.sv
// Line map: routes pins and on-chip events onto the group bit matrix.
// Assumes LINES <= 128 so that pins land only in groups 6..3.
module eic_line_map
    import eic_pkg::*;
(
    input  logic [LINES-1:0]          ext_lines,
    input  logic                      timer_evt,
    input  logic                      cable_evt,
    output logic [GROUPS-1:0][GW-1:0] raw
);
    // scatter every pin to its reversed group and byte position
    always_comb begin
        raw = '0;
        for (int n = 0; n < LINES; n++) begin
            raw[line_group(n)][line_bit(n)] = ext_lines[n];
        end
        raw[0][TMR_BIT] = timer_evt;
        raw[0][CBL_BIT] = cable_evt;
    end
endmodule

// File: rtl/eic_group_cell.sv
// Group cell: synchroniser, edge/level detection and pending status for one group.
// Assumes type/polarity/enable come from registers; clr is a one-cycle W1C mask.
module eic_group_cell
    import eic_pkg::*;
#(
    parameter gvec_t MASK = '1
)(
    input  logic  clk,
    input  logic  rst_n,
    input  gvec_t raw,
    input  gvec_t pol,
    input  gvec_t typ,
    input  gvec_t en,
    input  gvec_t clr,
    output gvec_t status,
    output logic  irq
);
    logic [SYNC-1:0][GW-1:0] sync_q;
    gvec_t prev_q;
    gvec_t cur;
    gvec_t act;
    gvec_t prev_act;
    gvec_t edge_w;
    gvec_t status_q;

    assign cur = sync_q[SYNC-1];

    // synchroniser chain for the raw lines
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else begin
            sync_q[0] <= raw;
            for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    // one-cycle history of the synchronised value
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    // both samples judged with today's polarity, so a flip alone is no edge
    always_comb begin
        act      = ~(cur ^ pol);
        prev_act = ~(prev_q ^ pol);
        edge_w   = act & ~prev_act;
    end

    // pending status: level bits follow the line, edge bits latch until W1C
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else status_q <= ((typ & act) | (~typ & (edge_w | (status_q & ~clr)))) & MASK;
    end

    assign status = status_q;
    assign irq    = |(status_q & en);

    // an edge-type rise needs a change on the synchronised line
    p_edge_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~$past(typ) & status_q & ~$past(status_q) & ~($past(cur) ^ $past(prev_q))) == '0));

    // edge-type bit with no event and no clear keeps its value
    p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(~typ & ~edge_w & ~clr) & (status_q ^ $past(status_q))) == '0));

    // a clear without a competing event leaves the bit low
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(~typ & clr & ~edge_w) & status_q) == '0));

    // level-type bit tracks the active state one cycle later
    p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(typ) & (status_q ^ ($past(act) & MASK))) == '0));

    // masked positions never go pending
    p_mask_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~MASK) == '0));

    // a polarity flip on a steady line never raises an edge-type bit
    p_flip_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((~$past(typ) & ($past(pol) ^ $past(pol, 2)) & ~($past(cur) ^ $past(prev_q))
          & status_q & ~$past(status_q)) == '0));
endmodule

// File: rtl/eic_regs.sv
// Register banks: polarity, enable and type storage, W1C strobes and the read mux.
// Assumes word-aligned accesses; writes take effect at the next clock edge.
module eic_regs
    import eic_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [GW-1:0]             bus_wdata,
    input  logic [GROUPS-1:0][GW-1:0] status,
    output logic [GROUPS-1:0][GW-1:0] pol,
    output logic [GROUPS-1:0][GW-1:0] en,
    output logic [GROUPS-1:0][GW-1:0] typ,
    output logic [GROUPS-1:0][GW-1:0] clr,
    output logic [GW-1:0]             bus_rdata
);
    logic [2:0]        bank;
    logic [2:0]        gsel;
    logic              aligned;

    assign bank    = bus_addr[7:5];
    assign gsel    = bus_addr[4:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    for (genvar g = 0; g < GROUPS; g++) begin : g_bank
        localparam gvec_t M = grp_mask(g);
        logic sel;
        assign sel = bus_we && aligned && (gsel == 3'(g));

        // store configuration words, masked bits forced to zero
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pol[g] <= '0;
                en[g]  <= '0;
                typ[g] <= '0;
            end else if (sel) begin
                if (bank == BANK_POL)  pol[g] <= bus_wdata & M;
                if (bank == BANK_EN)   en[g]  <= bus_wdata & M;
                if (bank == BANK_TYPE) typ[g] <= bus_wdata & M;
            end
        end

        // one-cycle clear strobe for the status bank
        assign clr[g] = (sel && bank == BANK_STAT) ? (bus_wdata & M) : '0;

        // reserved configuration bits stay zero
        p_mask_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (((pol[g] | en[g] | typ[g]) & ~M) == '0));
    end

    // combinational read of the addressed word
    always_comb begin
        bus_rdata = '0;
        if (aligned && gsel < 3'(GROUPS)) begin
            case (bank)
                BANK_POL:  bus_rdata = pol[gsel];
                BANK_STAT: bus_rdata = status[gsel];
                BANK_EN:   bus_rdata = en[gsel];
                BANK_TYPE: bus_rdata = typ[gsel];
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/grp_irq_ctrl.sv
// Top: grouped external interrupt controller with one combined request per group.
// Assumes inputs are asynchronous to clk; group g drives grp_irq[6-g].
module grp_irq_ctrl
    import eic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [GW-1:0]     bus_wdata,
    output logic [GW-1:0]     bus_rdata,
    input  logic [LINES-1:0]  ext_lines,
    input  logic              timer_evt,
    input  logic              cable_evt,
    output logic [GROUPS-1:0] grp_irq
);
    logic [GROUPS-1:0][GW-1:0] raw;
    logic [GROUPS-1:0][GW-1:0] pol;
    logic [GROUPS-1:0][GW-1:0] en;
    logic [GROUPS-1:0][GW-1:0] typ;
    logic [GROUPS-1:0][GW-1:0] clr;
    logic [GROUPS-1:0][GW-1:0] status;
    logic [GROUPS-1:0]         cell_irq;

    eic_line_map u_map (
        .ext_lines (ext_lines),
        .timer_evt (timer_evt),
        .cable_evt (cable_evt),
        .raw       (raw)
    );

    eic_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status    (status),
        .pol       (pol),
        .en        (en),
        .typ       (typ),
        .clr       (clr),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_cell
        eic_group_cell #(.MASK(grp_mask(g))) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (raw[g]),
            .pol    (pol[g]),
            .typ    (typ[g]),
            .en     (en[g]),
            .clr    (clr[g]),
            .status (status[g]),
            .irq    (cell_irq[g])
        );
        assign grp_irq[GROUPS-1-g] = cell_irq[g];

        // request low while nothing is both pending and enabled
        p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ((status[g] & en[g]) == '0) |-> !grp_irq[GROUPS-1-g]);
    end
endmodule

// File: tb/sim_grp_irq_ctrl.sv
`timescale 1ns/1ps
module sim_grp_irq_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] ext_lines = '0;
    logic         timer_evt = 1'b0;
    logic         cable_evt = 1'b0;
    logic [6:0]   grp_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // line, group, bit (255 = masked position)
    localparam logic [23:0] VTAB [10] = '{
        {8'd0,   8'd6, 8'd24}, {8'd7,   8'd6, 8'd31}, {8'd8,  8'd6, 8'd16},
        {8'd21,  8'd6, 8'd13}, {8'd31,  8'd6, 8'd7},  {8'd37, 8'd5, 8'd29},
        {8'd70,  8'd4, 8'd30}, {8'd99,  8'd3, 8'd27}, {8'd100, 8'd3, 8'd255},
        {8'd127, 8'd3, 8'd7}
    };

    always #2 clk = ~clk;

    grp_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_lines(ext_lines),
        .timer_evt(timer_evt), .cable_evt(cable_evt), .grp_irq(grp_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] a_pol(input int g);  return 8'(8'h80 + 4*g); endfunction
    function automatic logic [7:0] a_stat(input int g); return 8'(8'hA0 + 4*g); endfunction
    function automatic logic [7:0] a_en(input int g);   return 8'(8'hC0 + 4*g); endfunction
    function automatic logic [7:0] a_typ(input int g);  return 8'(8'hE0 + 4*g); endfunction

    initial begin
        logic [31:0] d;
        logic [31:0] zero_or;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        zero_or = '0;
        for (int g = 0; g < 7; g++) begin
            rd(a_pol(g), d);  zero_or |= d;
            rd(a_stat(g), d); zero_or |= d;
            rd(a_en(g), d);   zero_or |= d;
            rd(a_typ(g), d);  zero_or |= d;
        end
        chk("R1 regs", zero_or, 32'h0);
        chk("R1 irq", {25'h0, grp_irq}, 32'h0);

        // R2 / R9: register access and masked banks
        for (int g = 3; g < 7; g++) begin
            wr(a_pol(g), 32'hFFFF_FFFF);
            wr(a_en(g), 32'hFFFF_FFFF);
        end
        rd(a_pol(6), d); chk("R2 pol g6", d, 32'hFFFF_FFFF);
        rd(a_en(3), d);  chk("R9 en g3", d, 32'h0FFF_FFFF);
        wr(a_typ(6), 32'h1234_5678); rd(a_typ(6), d); chk("R2 type g6", d, 32'h1234_5678);
        wr(a_typ(6), 32'h0);
        wr(a_en(1), 32'hFFFF_FFFF); rd(a_en(1), d); chk("R9 en g1", d, 32'h0);
        rd(8'h10, d); chk("R2 unmapped", d, 32'h0);
        rd(8'h81, d); chk("R2 unaligned", d, 32'h0);

        // R3 / R4 / R6: vector table walk, edge mode, rising polarity
        for (int v = 0; v < 10; v++) begin
            int n; int g; int b; logic [31:0] exp;
            n = int'(VTAB[v][23:16]); g = int'(VTAB[v][15:8]); b = int'(VTAB[v][7:0]);
            exp = (b == 255) ? 32'h0 : (32'h1 << b);
            @(negedge clk); ext_lines[n] = 1'b1;
            wait_edges(2);
            rd(a_stat(g), d); chk("R4 latency early", d, 32'h0);
            wait_edges(1);
            rd(a_stat(g), d); chk("R3 map", d, exp);
            chk("R8 irq on", {31'h0, grp_irq[6-g]}, {31'h0, (b != 255)});
            ext_lines[n] = 1'b0;
            wait_edges(4);
            rd(a_stat(g), d); chk("R4 hold after fall", d, exp);
            wr(a_stat(g), 32'hFFFF_FFFF);
            rd(a_stat(g), d); chk("R6 w1c", d, 32'h0);
            chk("R8 irq off", {31'h0, grp_irq[6-g]}, 32'h0);
        end

        // R11: polarity flip on steady lines; R5: falling sensing
        wr(a_pol(6), 32'h0);
        wait_edges(4);
        rd(a_stat(6), d); chk("R11 flip no edge", d, 32'h0);
        @(negedge clk); ext_lines[0] = 1'b1;
        wait_edges(4);
        rd(a_stat(6), d); chk("R5 rise ignored", d, 32'h0);
        ext_lines[0] = 1'b0;
        wait_edges(2);
        rd(a_stat(6), d); chk("R5 fall early", d, 32'h0);
        wait_edges(1);
        rd(a_stat(6), d); chk("R5 fall sets", d, 32'h0100_0000);
        wr(a_stat(6), 32'h0);
        rd(a_stat(6), d); chk("R6 write zero", d, 32'h0100_0000);
        wr(a_stat(6), 32'h0100_0000);
        rd(a_stat(6), d); chk("R6 clear", d, 32'h0);

        // R7 / R8: level mode on line 37 (group 5 bit 29)
        wr(a_typ(5), 32'h2000_0000);
        @(negedge clk); ext_lines[37] = 1'b1;
        wait_edges(3);
        rd(a_stat(5), d); chk("R7 level set", d, 32'h2000_0000);
        wr(a_stat(5), 32'h2000_0000);
        rd(a_stat(5), d); chk("R7 w1c ignored", d, 32'h2000_0000);
        wr(a_en(5), 32'h0);
        chk("R8 disabled", {31'h0, grp_irq[1]}, 32'h0);
        wr(a_en(5), 32'hFFFF_FFFF);
        chk("R8 enabled", {31'h0, grp_irq[1]}, 32'h1);
        @(negedge clk); ext_lines[37] = 1'b0;
        wait_edges(2);
        rd(a_stat(5), d); chk("R7 level still", d, 32'h2000_0000);
        wait_edges(1);
        rd(a_stat(5), d); chk("R7 level drop", d, 32'h0);

        // R10 / R9: group 0 event sources
        wr(a_en(0), 32'hFFFF_FFFF);
        wr(a_pol(0), 32'hFFFF_FFFF);
        rd(a_pol(0), d); chk("R9 pol g0", d, 32'h5);
        @(negedge clk); timer_evt = 1'b1;
        wait_edges(3);
        rd(a_stat(0), d); chk("R10 timer", d, 32'h1);
        chk("R10 irq6", {31'h0, grp_irq[6]}, 32'h1);
        @(negedge clk); cable_evt = 1'b1;
        wait_edges(3);
        rd(a_stat(0), d); chk("R10 cable", d, 32'h5);
        wr(a_stat(0), 32'hFFFF_FFFF);
        rd(a_stat(0), d); chk("R10 clear", d, 32'h0);
        chk("R10 irq6 off", {31'h0, grp_irq[6]}, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule